// File: doc/BRIEF.md
# Transmit Command Consistency Checker

This block watches the host side of an Ethernet transmit path. The host builds a packet from one or more buffers. For each buffer it writes a first command word, then a second command word, then the buffer's data beats, all into the transmit data FIFO. The block parses that stream of writes. It checks that the words come in the right order and that the first-buffer and last-buffer markers are placed correctly. It also checks that every buffer of a packet repeats the same second command word, and that the bytes delivered for the packet add up to the length carried in that word.

The block also watches two overrun strobes. One comes from the data FIFO. The other comes from the transmit status FIFO, and it can be masked by a status-overwrite enable. Any violation sets one sticky error flag. The host clears the flag by pulsing a clear input. An error never stalls the block: it keeps parsing, so later packets are still checked.

Word kinds on `wr_kind`: 0 means a data beat, 1 means command word A, 2 means command word B, and 3 means no write. Command A holds the buffer byte count in bits [10:0], the last-segment marker in bit 12 and the first-segment marker in bit 13. Command B holds the packet length in bits [10:0] and a packet tag in bits [31:16]. It is compared as a full 32-bit word.

Top module: `txcc_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `tx_err` is 0.
- R2: The words of each buffer must arrive in the order A, then B, then data beats. The following each set `tx_err`: a data beat when no buffer is open, a B word that does not directly follow an A word, and an A word arriving before the current buffer's data is complete. The misplaced word is otherwise ignored. An out-of-place A word starts a new buffer.
- R3: For a buffer that is not the first of its packet, a B word that differs in any bit from the first buffer's B word sets `tx_err`.
- R4: A buffer completes on the data beat that brings its byte count (the sum of `wr_bytes` over its beats) to or past the A word's bits [10:0]. When the buffer marked last completes, `tx_err` is set if the packet's total delivered bytes differ from B bits [10:0]. When they are equal, `tx_err` is not set.
- R5: A `dfifo_ovf` strobe sets `tx_err`.
- R6: A `sfifo_ovf` strobe sets `tx_err` when `sts_ovwr_en` is 0, and has no effect when it is 1.
- R7: `tx_err` stays 1 until `err_clr` is pulsed, and then it falls. If a clear and a new error occur in the same cycle, `tx_err` stays 1.
- R8: After an error, checking carries on without a restart. A correct packet leaves the cleared flag at 0, and a faulty packet sets it again.
- R9: An A word with the first marker (bit 13) while a packet is open sets `tx_err` and restarts the packet. An A word without the first marker while no packet is open sets `tx_err` and opens a packet anyway.
- R10: A buffer whose A byte count is 0 completes on its B word. If it is also marked last, the length check of R4 is made at that point.
- R11: Every error source reaches `tx_err` on the clock edge that samples the offending input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A host write into the transmit data FIFO is present |
| wr_kind | input | 2 | Kind of word: 0 data, 1 command A, 2 command B |
| wr_word | input | 32 | Command word contents (ignored for data beats) |
| wr_bytes | input | 3 | Bytes carried by a data beat (0 to 4) |
| dfifo_ovf | input | 1 | Data FIFO overrun strobe |
| sfifo_ovf | input | 1 | Status FIFO overrun strobe |
| sts_ovwr_en | input | 1 | Status overwrite allowed; masks `sfifo_ovf` |
| err_clr | input | 1 | Write-one clear of the error flag |
| tx_err | output | 1 | Sticky transmit error flag |

## Verification
Every cause of the flag goes through exactly one register, so `tx_err` shows the result one clock after the offending write or strobe. The bench applies each stimulus at a falling edge and reads the flag at the next falling edge. That is the point just after the edge that captured the stimulus, so every check sits in the single cycle where the result is due. A length error appears one cycle after the beat that completes the last buffer, and the bench checks for it right after that beat. Sticky behaviour is checked several idle cycles later, and a clear is checked one cycle after its pulse.

// File: rtl/txcc_pkg.sv
package txcc_pkg;
    localparam int CMD_W       = 32;
    localparam int LEN_W       = 11;
    localparam int NB_W        = 3;
    localparam int A_LAST_BIT  = 12;
    localparam int A_FIRST_BIT = 13;
    localparam int B_TAG_LSB   = 16;

    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_CMDA = 2'd1,
        WK_CMDB = 2'd2,
        WK_IDLE = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        PH_WAIT_A = 2'd0,
        PH_WAIT_B = 2'd1,
        PH_DATA   = 2'd2
    } phase_e;
endpackage

// File: rtl/txcc_seq.sv
module txcc_seq
    import txcc_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int BW = NB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_kind,
    input  logic [CMD_W-1:0] wr_word,
    input  logic [BW-1:0]    wr_bytes,
    output logic             proto_err,
    output logic             b_mismatch,
    output logic             pkt_start,
    output logic             beat_acc,
    output logic             pkt_done,
    output logic [LW-1:0]    ref_len
);
    localparam int CNT_W = LW + 1;

    typedef struct packed {
        phase_e           phase;
        logic             open;
        logic             first;
        logic             last;
        logic [LW-1:0]    size;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] ref_b;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] cnt_sum;
    logic             a_first;
    word_kind_e       kind;

    always_comb begin
        seq_d      = seq_q;
        proto_err  = 1'b0;
        b_mismatch = 1'b0;
        pkt_start  = 1'b0;
        beat_acc   = 1'b0;
        pkt_done   = 1'b0;
        kind       = word_kind_e'(wr_kind);
        a_first    = wr_word[A_FIRST_BIT];
        cnt_sum    = seq_q.cnt + CNT_W'(wr_bytes);
        if (wr_valid) begin
            case (kind)
                WK_CMDA: begin
                    if (seq_q.phase != PH_WAIT_A) proto_err = 1'b1;
                    if (a_first && seq_q.open)    proto_err = 1'b1;
                    if (!a_first && !seq_q.open)  proto_err = 1'b1;
                    seq_d.first = a_first || !seq_q.open;
                    seq_d.last  = wr_word[A_LAST_BIT];
                    seq_d.size  = wr_word[LW-1:0];
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_WAIT_B;
                    seq_d.open  = 1'b1;
                    pkt_start   = seq_d.first;
                end
                WK_CMDB: begin
                    if (seq_q.phase != PH_WAIT_B) begin
                        proto_err = 1'b1;
                    end else begin
                        if (seq_q.first) begin
                            seq_d.ref_b = wr_word;
                        end else if (wr_word != seq_q.ref_b) begin
                            b_mismatch = 1'b1;
                        end
                        if (seq_q.size == '0) begin
                            seq_d.phase = PH_WAIT_A;
                            if (seq_q.last) begin
                                pkt_done   = 1'b1;
                                seq_d.open = 1'b0;
                            end
                        end else begin
                            seq_d.phase = PH_DATA;
                        end
                    end
                end
                WK_DATA: begin
                    if (seq_q.phase != PH_DATA) begin
                        proto_err = 1'b1;
                    end else begin
                        beat_acc  = 1'b1;
                        seq_d.cnt = cnt_sum;
                        if (cnt_sum >= {1'b0, seq_q.size}) begin
                            seq_d.phase = PH_WAIT_A;
                            if (seq_q.last) begin
                                pkt_done   = 1'b1;
                                seq_d.open = 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        ref_len = seq_d.ref_b[LW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_WAIT_A, open: 1'b0, first: 1'b0, last: 1'b0,
                       size: '0, cnt: '0, ref_b: '0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/txcc_len.sv
module txcc_len #(
    parameter int LW = 11,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic          beat_acc,
    input  logic          pkt_done,
    input  logic [BW-1:0] wr_bytes,
    input  logic [LW-1:0] ref_len,
    output logic          len_err
);
    localparam int ACC_W = LW + 2;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   sum_wide;
    logic [ACC_W-1:0] sum_sat;

    always_comb begin
        sum_wide = {1'b0, acc_q} + (beat_acc ? (ACC_W + 1)'(wr_bytes) : '0);
        sum_sat  = sum_wide[ACC_W] ? '1 : sum_wide[ACC_W-1:0];
        len_err  = pkt_done && (sum_sat != ACC_W'(ref_len));
        acc_d    = acc_q;
        if (pkt_start || pkt_done) begin
            acc_d = '0;
        end else if (beat_acc) begin
            acc_d = sum_sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/txcc_flag.sv
module txcc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic err_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = err_set | (flag_q & ~err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/txcc_top.sv
module txcc_top
    import txcc_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int BW = NB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_kind,
    input  logic [CMD_W-1:0] wr_word,
    input  logic [BW-1:0]    wr_bytes,
    input  logic             dfifo_ovf,
    input  logic             sfifo_ovf,
    input  logic             sts_ovwr_en,
    input  logic             err_clr,
    output logic             tx_err
);
    logic          proto_err, b_mismatch, pkt_start, beat_acc, pkt_done, len_err;
    logic [LW-1:0] ref_len;
    logic          err_set;

    txcc_seq #(.LW(LW), .BW(BW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_kind    (wr_kind),
        .wr_word    (wr_word),
        .wr_bytes   (wr_bytes),
        .proto_err  (proto_err),
        .b_mismatch (b_mismatch),
        .pkt_start  (pkt_start),
        .beat_acc   (beat_acc),
        .pkt_done   (pkt_done),
        .ref_len    (ref_len)
    );

    txcc_len #(.LW(LW), .BW(BW)) len_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .beat_acc  (beat_acc),
        .pkt_done  (pkt_done),
        .wr_bytes  (wr_bytes),
        .ref_len   (ref_len),
        .len_err   (len_err)
    );

    assign err_set = proto_err | b_mismatch | len_err | dfifo_ovf
                   | (sfifo_ovf & ~sts_ovwr_en);

    txcc_flag flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_set (err_set),
        .err_clr (err_clr),
        .flag    (tx_err)
    );
endmodule

// File: rtl/txcc_chk.sv
module txcc_chk (
    input logic clk,
    input logic rst_n,
    input logic dfifo_ovf,
    input logic sfifo_ovf,
    input logic sts_ovwr_en,
    input logic err_clr,
    input logic err_set,
    input logic tx_err
);
    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |=> !tx_err);

    // R5
    dfifo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dfifo_ovf |=> tx_err);

    // R6
    sfifo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfifo_ovf && !sts_ovwr_en) |=> tx_err);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !err_clr) |=> tx_err);

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_set) |=> !tx_err);

    // R11
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_err && !err_set) |=> !tx_err);
endmodule

bind txcc_top txcc_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dfifo_ovf   (dfifo_ovf),
    .sfifo_ovf   (sfifo_ovf),
    .sts_ovwr_en (sts_ovwr_en),
    .err_clr     (err_clr),
    .err_set     (err_set),
    .tx_err      (tx_err)
);

// File: tb/txcc_top_tb_top.sv
`timescale 1ns/1ps
module txcc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [31:0] wr_word = '0;
    logic [2:0]  wr_bytes = '0;
    logic        dfifo_ovf = 1'b0;
    logic        sfifo_ovf = 1'b0;
    logic        sts_ovwr_en = 1'b0;
    logic        err_clr = 1'b0;
    logic        tx_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    txcc_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_kind     (wr_kind),
        .wr_word     (wr_word),
        .wr_bytes    (wr_bytes),
        .dfifo_ovf   (dfifo_ovf),
        .sfifo_ovf   (sfifo_ovf),
        .sts_ovwr_en (sts_ovwr_en),
        .err_clr     (err_clr),
        .tx_err      (tx_err)
    );

    task automatic check(input string what, input logic exp);
        checks++;
        if (tx_err !== exp) begin
            fails++;
            $display("FAIL %s: tx_err=%0b expected %0b", what, tx_err, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [1:0] k, input logic [31:0] w, input logic [2:0] n);
        wr_valid = 1'b1; wr_kind = k; wr_word = w; wr_bytes = n;
        @(negedge clk);
        wr_valid = 1'b0; wr_kind = 2'd3;
    endtask

    function automatic logic [31:0] a_word(input bit f, input bit l, input int size);
        return (32'(f) << 13) | (32'(l) << 12) | 32'(size & 11'h7ff);
    endfunction

    function automatic logic [31:0] b_word(input int tag, input int len);
        return (32'(tag & 16'hffff) << 16) | 32'(len & 11'h7ff);
    endfunction

    task automatic send_buf(input bit f, input bit l, input int size, input int bw,
                            input logic [31:0] bw_word);
        int rem;
        put(2'd1, a_word(f, l, size), 3'd0);
        put(2'd2, bw_word, 3'd0);
        rem = size;
        while (rem > 0) begin
            int n;
            n = (rem < bw) ? rem : bw;
            put(2'd0, 32'h0, 3'(n));
            rem -= n;
        end
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1 flag low in reset", 1'b0);
        do_reset();
        check("R1 flag low after reset", 1'b0);

        // R4: sweep buffer count, beat width and length offset
        for (int nb = 1; nb <= 3; nb++) begin
            for (int bw = 1; bw <= 4; bw++) begin
                for (int dl = -2; dl <= 2; dl++) begin
                    int total;
                    total = 0;
                    for (int i = 0; i < nb; i++) total += ((5 + 3 * i) % 8) + 1;
                    do_reset();
                    for (int i = 0; i < nb; i++) begin
                        send_buf(i == 0, i == nb - 1, ((5 + 3 * i) % 8) + 1, bw,
                                 b_word(16'h1234, total + dl));
                    end
                    check($sformatf("R4 nb=%0d bw=%0d dl=%0d", nb, bw, dl), dl != 0);
                end
            end
        end

        // R3: B mismatch in a later buffer (tag bit or length bit)
        for (int bad = 0; bad <= 2; bad++) begin
            for (int kind = 0; kind <= 1; kind++) begin
                logic [31:0] base;
                base = b_word(16'h00a5, 12);
                do_reset();
                for (int i = 0; i < 3; i++) begin
                    logic [31:0] w;
                    w = base;
                    if (bad != 0 && i == bad) w = base ^ (kind == 0 ? 32'h0001_0000 : 32'h0000_0001);
                    send_buf(i == 0, i == 2, 4, 4, w);
                end
                check($sformatf("R3 bad_buf=%0d kind=%0d", bad, kind), bad != 0);
            end
        end

        // R2: ordering faults
        do_reset();
        put(2'd0, 32'h0, 3'd4);
        check("R2 data with no buffer open", 1'b1);
        do_reset();
        put(2'd2, b_word(1, 4), 3'd0);
        check("R2 B without A", 1'b1);
        do_reset();
        put(2'd1, a_word(1, 1, 4), 3'd0);
        check("R2 A alone ok", 1'b0);
        put(2'd0, 32'h0, 3'd4);
        check("R2 data before B", 1'b1);
        do_reset();
        put(2'd1, a_word(1, 0, 8), 3'd0);
        put(2'd2, b_word(1, 8), 3'd0);
        put(2'd0, 32'h0, 3'd4);
        check("R2 partial buffer ok", 1'b0);
        put(2'd1, a_word(0, 1, 4), 3'd0);
        check("R2 A before buffer complete", 1'b1);

        // R9: misplaced first markers
        do_reset();
        put(2'd1, a_word(0, 1, 4), 3'd0);
        check("R9 continuation with no packet", 1'b1);
        do_reset();
        send_buf(1'b1, 1'b0, 4, 4, b_word(2, 8));
        check("R9 first buffer ok", 1'b0);
        send_buf(1'b1, 1'b1, 4, 4, b_word(2, 4));
        check("R9 first marker inside packet", 1'b1);
        pulse_clr();
        check("R9 restarted packet ends clean", 1'b0);

        // R10: zero-size buffer completes at B
        do_reset();
        send_buf(1'b1, 1'b1, 0, 4, b_word(3, 0));
        check("R10 empty packet length 0", 1'b0);
        send_buf(1'b1, 1'b1, 0, 4, b_word(3, 4));
        check("R10 empty packet length 4", 1'b1);

        // R5 / R11: data FIFO overrun, due one edge later
        do_reset();
        dfifo_ovf = 1'b1; @(negedge clk); dfifo_ovf = 1'b0;
        check("R5 R11 data overrun", 1'b1);

        // R7: sticky, clear, clear with concurrent error
        repeat (3) @(negedge clk);
        check("R7 flag held", 1'b1);
        pulse_clr();
        check("R7 flag cleared", 1'b0);
        dfifo_ovf = 1'b1; @(negedge clk); dfifo_ovf = 1'b0;
        err_clr = 1'b1; dfifo_ovf = 1'b1; @(negedge clk);
        err_clr = 1'b0; dfifo_ovf = 1'b0;
        check("R7 clear with new error", 1'b1);

        // R6: status overrun masked or not
        do_reset();
        sts_ovwr_en = 1'b1; sfifo_ovf = 1'b1; @(negedge clk); sfifo_ovf = 1'b0;
        check("R6 status overrun masked", 1'b0);
        sts_ovwr_en = 1'b0; sfifo_ovf = 1'b1; @(negedge clk); sfifo_ovf = 1'b0;
        check("R6 status overrun unmasked", 1'b1);

        // R8: checking continues after an error
        pulse_clr();
        send_buf(1'b1, 1'b0, 3, 2, b_word(9, 7));
        send_buf(1'b0, 1'b1, 4, 3, b_word(9, 7));
        check("R8 good packet after error", 1'b0);
        send_buf(1'b1, 1'b1, 5, 4, b_word(9, 6));
        check("R8 bad packet after error", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule